// File: doc/BRIEF.md
# Multi-channel timebase timer

This block provides four down-counting event channels and one free-running timestamp counter, all programmed over a plain 32-bit register read/write bus. A single control word carries, per event channel, an enable bit, a periodic/one-shot bit and a 2-bit timebase code, plus a 3-bit timebase code for the timestamp counter. The timebases are built inside the block from the system clock: a prescaler divides by `CLK_PER_US` to make a 1 µs tick, and a chain of divide-by-ten stages makes the 10 µs, 100 µs and 1 ms ticks. Each tick is a single-cycle enable pulse.

Software writes a channel's reload register while the channel is off, then sets its mode and enable bits. On every tick of its selected timebase the channel counts down. When a tick arrives with the count already at zero, the channel raises a one-cycle interrupt pulse. In periodic mode it then reloads. In one-shot mode it clears its own enable bit. Because the expiry tick is the one that finds zero, a reload of N gives a period of N+1 ticks. The timestamp counter counts up by one on each tick of its selected source and can be read at any time.

Top module: `mtimer_top`

## Requirements
- R1: After reset the control word, all four reload registers and `irq_o` are zero. With control code 0 the timestamp counter starts from zero on the system clock, so a read issued on the second edge after reset release returns 1.
- R2: `bus_addr` carries a word index: 0 is control, 1 to 4 are the reload registers of channels 0 to 3, and 5 is the timestamp (byte offsets 0x00 to 0x14). A write is taken on the edge where `bus_wr` is high. `bus_rdata` is loaded on the edge where `bus_rd` is high and holds that value until the next read. Indexes 6 and 7 read zero and ignore writes. Reload registers return their low 16 bits, zero-extended.
- R3: In the control word, bit 16+i enables channel i and bit 12+i selects periodic (1) or one-shot (0) for it. Bits [2i+1:2i] hold the channel's timebase code and bits [10:8] hold the timestamp code. Bit 11 and bits 31:20 always read zero.
- R4: Channel timebase codes 0, 1, 2 and 3 give ticks every `CLK_PER_US`, 10x, 100x and 1000x that many cycles.
- R5: An enabled periodic channel with reload L pulses every (L+1)·T cycles exactly, where T is its tick period. Its first pulse comes between L·T+1 and (L+1)·T cycles after the enabling write edge.
- R6: A one-shot channel with reload L pulses once, inside the same window as R5. After that pulse its enable bit reads 0 and it raises no further pulse.
- R7: A control write that clears a channel's enable bit keeps that channel's `irq_o` bit low from the next cycle on.
- R8: Enabling a disabled channel loads its count from the reload register, whatever count was left from its previous run.
- R9: Timestamp code 0 counts every system clock, codes 1 to 4 count the 1 µs, 10 µs, 100 µs and 1 ms ticks, and codes 5 to 7 hold the value. The counter is 32 bits wide, counts up by one per tick and wraps.
- R10: Each interrupt pulse is exactly one clock cycle wide (requires `CLK_PER_US` >= 2).
- R11: Channels run independently: two enabled channels keep their own periods, and disabling one leaves the other's period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 4 | One-cycle expiry pulse per channel |

## Verification
Read data is due on the clock edge that samples `bus_rd`. An interrupt rises on the edge after the cycle in which the expiring tick is present. The bench counts its own edges with a free cycle counter and samples every output at the falling edge, so each latency is an exact edge count.

Periodic spacing does not depend on the phase of the tick generator, so it is compared for equality. The first expiry after an enable does depend on that phase, so it is checked against the one-tick window L·T+1 to (L+1)·T.

Timestamp deltas are taken from two reads placed a whole number of tick periods apart. Any run of T consecutive cycles holds exactly one tick, so the expected difference is exact.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int NUM_CH  = 4;
  localparam int NUM_TB  = 4;   // 1us, 10us, 100us, 1ms
  localparam int EN_LSB  = 16;
  localparam int MODE_LSB = 12;
  localparam int STB_LSB = 8;
  localparam int STB_W   = 3;
  localparam int CTB_W   = 2;
  localparam logic [31:0] CTRL_MASK = 32'h000F_F7FF;

  typedef enum logic [STB_W-1:0] {
    STB_SYS   = 3'd0,
    STB_1US   = 3'd1,
    STB_10US  = 3'd2,
    STB_100US = 3'd3,
    STB_1MS   = 3'd4
  } stamp_tb_e;

  typedef struct packed {
    logic             en;
    logic             periodic;
    logic [CTB_W-1:0] tb;
  } chan_cfg_t;

  // Slice one channel's fields out of the control word.
  function automatic chan_cfg_t chan_cfg(input logic [31:0] c, input int unsigned i);
    chan_cfg_t r;
    r.en       = c[EN_LSB + i];
    r.periodic = c[MODE_LSB + i];
    r.tb       = c[CTB_W*i +: CTB_W];
    return r;
  endfunction

  // Channel timebase: code n selects tick n of the decade chain.
  function automatic logic pick_chan_tick(input logic [CTB_W-1:0] code,
                                          input logic [NUM_TB-1:0] t);
    return t[code];
  endfunction

  // Timestamp source: system clock, one of the four ticks, or hold.
  function automatic logic pick_stamp_tick(input logic [STB_W-1:0] code,
                                           input logic [NUM_TB-1:0] t);
    logic r;
    case (stamp_tb_e'(code))
      STB_SYS:   r = 1'b1;
      STB_1US:   r = t[0];
      STB_10US:  r = t[1];
      STB_100US: r = t[2];
      STB_1MS:   r = t[3];
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mtimer_tick_gen.sv
module mtimer_tick_gen #(
  parameter int CLK_PER_US = 250,
  parameter int DIV        = 10,
  parameter int STAGES     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [STAGES:0] tick_o
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int DEC_W = $clog2(DIV);

  logic [PRE_W-1:0] pre_q;

  assign tick_o[0] = (pre_q == PRE_W'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         pre_q <= '0;
    else if (tick_o[0]) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_dec
    logic [DEC_W-1:0] dec_q;
    logic             wrap_w;

    assign wrap_w    = (dec_q == DEC_W'(DIV - 1));
    assign tick_o[g] = tick_o[g-1] && wrap_w;

    always_ff @(posedge clk) begin
      if (!rst_n)           dec_q <= '0;
      else if (tick_o[g-1]) dec_q <= wrap_w ? '0 : dec_q + 1'b1;
    end
  end

endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             fire_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero_w;

  // Count after a tick: reload or park at zero on expiry, else step down.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r,
                                                  input logic per);
    if (c == '0) return per ? r : '0;
    return c - 1'b1;
  endfunction

  assign at_zero_w = (cnt_q == '0);
  assign fire_o    = en_i && tick_i && at_zero_w && !kill_i && !start_i;
  assign irq_o     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire_o;
      if (start_i)              cnt_q <= reload_i;
      else if (en_i && tick_i)  cnt_q <= step_count(cnt_q, reload_i, periodic_i);
    end
  end

endmodule

// File: rtl/mtimer_stamp.sv
module mtimer_stamp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] cnt_q;

  assign value_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int CNT_W      = 16,
  parameter int STAMP_W    = 32,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAMP = NUM_CH + 1;

  logic [NUM_TB-1:0]       tick_w;
  logic [31:0]             ctrl_q, ctrl_d;
  logic                    ctrl_wr_w;
  logic [NUM_CH*CNT_W-1:0] reload_all_w;
  logic [NUM_CH-1:0]       en_w, per_w, chan_tick_w, chan_fire_w, start_w, kill_w;
  logic                    stamp_inc_w;
  logic [STAMP_W-1:0]      stamp_q;
  logic [31:0]             rd_mux_w, rdata_q;

  mtimer_tick_gen #(
    .CLK_PER_US(CLK_PER_US),
    .DIV       (10),
    .STAGES    (NUM_TB - 1)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick_w)
  );

  assign ctrl_wr_w = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_cfg_t        cfg_w;
    logic [CNT_W-1:0] reload_q;

    assign cfg_w          = chan_cfg(ctrl_q, i);
    assign en_w[i]        = cfg_w.en;
    assign per_w[i]       = cfg_w.periodic;
    assign chan_tick_w[i] = pick_chan_tick(cfg_w.tb, tick_w);
    assign start_w[i]     = ctrl_wr_w && bus_wdata[EN_LSB + i] && !cfg_w.en;
    assign kill_w[i]      = ctrl_wr_w && !bus_wdata[EN_LSB + i];
    assign reload_all_w[i*CNT_W +: CNT_W] = reload_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        reload_q <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(i + 1))
        reload_q <= bus_wdata[CNT_W-1:0];
    end

    mtimer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (cfg_w.en),
      .periodic_i(cfg_w.periodic),
      .tick_i    (chan_tick_w[i]),
      .start_i   (start_w[i]),
      .kill_i    (kill_w[i]),
      .reload_i  (reload_q),
      .fire_o    (chan_fire_w[i]),
      .irq_o     (irq_o[i])
    );
  end

  // Control word: a bus write wins; otherwise one-shot expiries drop their enable.
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr_w) begin
      ctrl_d = bus_wdata & CTRL_MASK;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (chan_fire_w[i] && !per_w[i]) ctrl_d[EN_LSB + i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign stamp_inc_w = pick_stamp_tick(ctrl_q[STB_LSB +: STB_W], tick_w);

  mtimer_stamp #(.W(STAMP_W)) u_stamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (stamp_inc_w),
    .value_o(stamp_q)
  );

  always_comb begin
    rd_mux_w = '0;
    if (bus_addr == ADDR_W'(IDX_CTRL)) begin
      rd_mux_w = ctrl_q;
    end else if (bus_addr == ADDR_W'(IDX_STAMP)) begin
      rd_mux_w = 32'(stamp_q);
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (bus_addr == ADDR_W'(i + 1)) rd_mux_w = 32'(reload_all_w[i*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux_w;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int STAMP_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CH-1:0]  irq_i,
  input logic [NUM_TB-1:0]  tick_i,
  input logic [NUM_CH-1:0]  chan_tick_i,
  input logic [NUM_CH-1:0]  fire_i,
  input logic [NUM_CH-1:0]  en_i,
  input logic [NUM_CH-1:0]  per_i,
  input logic               ctrl_wr_i,
  input logic [NUM_CH-1:0]  wen_i,
  input logic               stamp_inc_i,
  input logic [STAMP_W-1:0] stamp_i
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[i] |=> !irq_i[i]); // R10
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[i] |-> $past(chan_tick_i[i])); // R5
    AST_ONESHOT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i[i] && !per_i[i] && !ctrl_wr_i) |=> !en_i[i]); // R6
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && !wen_i[i]) |=> !irq_i[i]); // R7
  end

  for (genvar k = 0; k < NUM_TB - 1; k++) begin : g_t
    AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i[k+1] |-> tick_i[k]); // R4
  end

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_inc_i |=> (stamp_i == $past(stamp_i) + 1'b1)); // R9
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_inc_i |=> $stable(stamp_i)); // R9

endmodule

bind mtimer_top mtimer_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_i      (irq_o),
  .tick_i     (tick_w),
  .chan_tick_i(chan_tick_w),
  .fire_i     (chan_fire_w),
  .en_i       (en_w),
  .per_i      (per_w),
  .ctrl_wr_i  (ctrl_wr_w),
  .wen_i      (bus_wdata[mtimer_pkg::EN_LSB +: mtimer_pkg::NUM_CH]),
  .stamp_inc_i(stamp_inc_w),
  .stamp_i    (stamp_q)
);

// File: tb/tb_mtimer_top.sv
module tb_mtimer_top;
  localparam int P = 4;   // cycles per 1 us tick in this bench

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mtimer_top #(.CLK_PER_US(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  function automatic logic [31:0] en_b(input int i);   return 32'h1 << (16 + i); endfunction
  function automatic logic [31:0] per_b(input int i);  return 32'h1 << (12 + i); endfunction
  function automatic logic [31:0] tb_b(input int i, input int c); return 32'(c) << (2 * i); endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input string what, input longint act,
                         input longint lo, input longint hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wait_irq(input int ch, output int at);
    int n = 0;
    do begin @(negedge clk); n++; end while (!irq[ch] && n < 20000);
    at = irq[ch] ? cyc : -1;
  endtask

  task automatic meas_period(input int ch, input string req, input int exp);
    int t1, t2;
    wait_irq(ch, t1);
    @(negedge clk);
    chk("R10", "pulse width", irq[ch], 0);
    wait_irq(ch, t2);
    chk(req, $sformatf("period ch%0d", ch), t2 - t1, exp);
  endtask

  task automatic count_pulses(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (irq[ch]) cnt++; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    br(3'd5, d); chk("R1", "stamp after reset", d, 1);
    chk("R1", "irq at reset", irq, 0);
    for (int a = 0; a < 5; a++) begin
      br(3'(a), d); chk("R1", $sformatf("reg %0d at reset", a), d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bw(3'(i + 1), 32'h0001_0100 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      br(3'(i + 1), d); chk("R2", $sformatf("reload %0d readback", i), d, 32'h100 + i);
    end
    bw(3'd6, 32'hFFFF_FFFF);
    br(3'd6, d); chk("R2", "index 6 reads zero", d, 0);
    br(3'd7, d); chk("R2", "index 7 reads zero", d, 0);
    bw(3'd0, 32'hFFFF_FFFF);
    br(3'd0, d); chk("R3", "control reserved bits", d, 32'h000F_F7FF);
    bw(3'd0, 32'h0);
    br(3'd0, d); chk("R3", "control cleared", d, 0);
  endtask

  task automatic t_ticks();
    int exp;
    bw(3'd1, 0);
    exp = P;
    for (int c = 0; c < 4; c++) begin
      bw(3'd0, en_b(0) | per_b(0) | tb_b(0, c));
      meas_period(0, "R4", exp);
      bw(3'd0, 0);
      exp = exp * 10;
    end
  endtask

  task automatic t_periodic();
    bw(3'd1, 2);
    bw(3'd0, en_b(0) | per_b(0));
    meas_period(0, "R5", 3 * P);
    bw(3'd3, 4);
    bw(3'd0, en_b(2) | per_b(2) | tb_b(2, 1));
    meas_period(2, "R5", 5 * 10 * P);
    bw(3'd0, 0);
  endtask

  task automatic t_oneshot();
    int c0, t, n;
    logic [31:0] d;
    bw(3'd2, 3);
    bw(3'd0, en_b(1));
    c0 = cyc;
    wait_irq(1, t);
    chk_win("R6", "one-shot latency", t - c0, 3 * P + 1, 4 * P);
    @(negedge clk);
    chk("R10", "one-shot pulse width", irq[1], 0);
    count_pulses(1, 20 * P, n);
    chk("R6", "one-shot extra pulses", n, 0);
    br(3'd0, d); chk("R6", "enable self-cleared", d, 0);
  endtask

  task automatic t_disable();
    int t, n;
    bw(3'd4, 0);
    bw(3'd0, en_b(3) | per_b(3));
    wait_irq(3, t);
    bw(3'd0, 0);
    chk("R7", "irq right after disable", irq[3], 0);
    count_pulses(3, 25 * P, n);
    chk("R7", "pulses after disable", n, 0);
  endtask

  task automatic t_reenable();
    int c0, t;
    bw(3'd1, 9);
    bw(3'd0, en_b(0) | per_b(0));
    repeat (11) @(negedge clk);
    bw(3'd0, 0);
    bw(3'd1, 1);
    bw(3'd0, en_b(0) | per_b(0));
    c0 = cyc;
    wait_irq(0, t);
    chk_win("R8", "first expiry after re-enable", t - c0, P + 1, 2 * P);
    meas_period(0, "R8", 2 * P);
    bw(3'd0, 0);
  endtask

  task automatic t_indep();
    int n;
    bw(3'd1, 1);
    bw(3'd2, 3);
    bw(3'd0, en_b(0) | per_b(0) | en_b(1) | per_b(1));
    meas_period(0, "R11", 2 * P);
    meas_period(1, "R11", 4 * P);
    bw(3'd0, en_b(0) | per_b(0));
    meas_period(0, "R11", 2 * P);
    count_pulses(1, 16 * P, n);
    chk("R11", "disabled neighbour pulses", n, 0);
    bw(3'd0, 0);
  endtask

  task automatic stamp_delta(input int code, input int spacing, input int exp);
    logic [31:0] a, b;
    bw(3'd0, 32'(code) << 8);
    br(3'd5, a);
    repeat (spacing - 2) @(negedge clk);
    br(3'd5, b);
    chk("R9", $sformatf("stamp delta code %0d", code), b - a, exp);
  endtask

  task automatic t_stamp();
    stamp_delta(0, 10 * P, 10 * P);
    stamp_delta(1, 10 * P, 10);
    stamp_delta(2, 100 * P, 10);
    stamp_delta(3, 200 * P, 2);
    stamp_delta(4, 1000 * P, 1);
    stamp_delta(5, 10 * P, 0);
    stamp_delta(7, 10 * P, 0);
    bw(3'd0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_ticks();
    t_periodic();
    t_oneshot();
    t_disable();
    t_reenable();
    t_indep();
    t_stamp();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected=done", cyc);
      summary();
      $finish;
    end
  end

endmodule